// File: doc/BRIEF.md
# Self-Expiring Read-Only L1 Data Cache

This block is a private first-level data cache that keeps read-only copies of memory blocks. It never receives invalidation messages. Each cached line carries a lease time handed out by the block's home node. The line may satisfy loads only while an externally supplied global time is still below that lease. Once the time reaches the lease, the line silently stops hitting. The home node can then perform a pending write with no acknowledgement traffic.

Core loads look up the cache. A hit returns the requested word one cycle later. A miss sends a line-aligned read request to the home node over a valid/ready handshake and stalls further loads. Later a fill arrives with the whole line and its lease time. The requested word is always forwarded to the core. The line is installed only if the lease has not already run out. Core stores bypass the cache entirely and are passed straight through to the home node. A line may be replaced at any time without telling anyone.

Top module: `lease_l1_cache`

## Requirements
- R1: After reset, `ldReady` is 1, `missReqValid` and `ldRespValid` are 0, and the cache holds no lines, so the first load to any address misses.
- R2: A load accepted (`ldValid && ldReady`) whose tag matches a valid line with a live lease is a hit. `ldRespValid` pulses in the next cycle with the addressed word, and no miss request is issued.
- R3: A line whose lease has been reached by the global time misses, even though its tag still matches.
- R4: A missing load raises `missReqValid` in the next cycle with the line-aligned address (byte offset bits [4:0] zero). Valid and address hold until `missReqReady`. `ldReady` stays 0 from the miss until the response, so only one miss is outstanding.
- R5: A fill (`fillValid` one cycle) with a live lease is installed. The requested word is forwarded on `ldRespValid`/`ldRespData` in the cycle after the fill, and a later load to the line hits.
- R6: A fill whose lease is already at or below the global time still forwards the requested word in the cycle after the fill. It is not installed, so the next load to that line misses.
- R7: Stores bypass the cache. `homeStValid`, `homeStAddr` and `homeStData` follow `stValid`, `stAddr` and `stData` in the same cycle, and `stReady` follows `homeStReady`. A store has no effect on a cached copy: a later load to that line within the lease returns the old data.
- R8: The cache is 8 KB, 2-way set associative with 32-byte lines. The byte address splits into word [4:2], set [11:5] and tag [31:12]. A fill goes into the way already holding its tag, if any. Otherwise it goes into the least recently used way of the set, where both hits and installs count as uses. An empty set fills way 0 first.
- R9: Lease comparison is wrap-safe. With d = (lease − time) taken modulo 2^16, a lease is live exactly when d is nonzero and d[15] is 0. For example, lease 0x0010 at time 0xFFF0 is live, and lease time+0x8000 is not.
- R10: The global time is an input. Advancing it alone, with no other stimulus, expires cached lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| globalTime | input | 16 | Global time shared by all caches |
| ldValid | input | 1 | Core load request |
| ldAddr | input | 32 | Load byte address |
| ldReady | output | 1 | Cache can accept a load |
| ldRespValid | output | 1 | Load response pulse |
| ldRespData | output | 32 | Loaded word |
| stValid | input | 1 | Core store request |
| stAddr | input | 32 | Store byte address |
| stData | input | 32 | Store data |
| stReady | output | 1 | Store accepted by home path |
| homeStValid | output | 1 | Store forwarded to home node |
| homeStAddr | output | 32 | Forwarded store address |
| homeStData | output | 32 | Forwarded store data |
| homeStReady | input | 1 | Home node accepts the store |
| missReqValid | output | 1 | Read miss request to home node |
| missReqAddr | output | 32 | Line-aligned miss address |
| missReqReady | input | 1 | Home node accepts the miss request |
| fillValid | input | 1 | Fill line arriving |
| fillData | input | 256 | Whole line, word 0 in bits [31:0] |
| fillExpiry | input | 16 | Lease time of the fill |

## Verification
The bench goes after the lease boundary itself. A load issued exactly when the global time equals the stored lease must miss, and an off-by-one compare would hit on stale data there. It also drives fills whose lease has already run out, which a design that installs unconditionally would later serve as hits. Lease values across the counter wrap-around are covered too, where a plain magnitude compare would call a live line dead or a dead one live. Replacement is checked with a third tag in a full set and with a refill of an expired line that still holds its tag. A wrong victim choice would evict the recently used line or leave two ways holding the same tag. Finally, stores are interleaved with loads to confirm that a store neither stalls nor disturbs a cached copy.

// File: rtl/lease_l1_pkg.sv
package lease_l1_pkg;
  // Control strobes sent from the sequencer to the datapath.
  typedef struct packed {
    logic captureReq;  // latch the accepted load address
    logic respHit;     // answer from the array this cycle
    logic respFill;    // answer from the incoming fill this cycle
    logic install;     // write the incoming fill into the array
  } ctlStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } ctlState_t;
endpackage

// File: rtl/lease_l1_ctrl.sv
module lease_l1_ctrl
  import lease_l1_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ldValid,
  input  logic       lookupHit,
  input  logic       missReqReady,
  input  logic       fillValid,
  input  logic       fillLive,
  output logic       ldReady,
  output logic       missReqValid,
  output ctlStrobe_t strobe
);
  ctlState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext    = state;
    strobe       = '0;
    ldReady      = 1'b0;
    missReqValid = 1'b0;
    unique case (state)
      ST_IDLE: begin
        ldReady = 1'b1;
        if (ldValid) begin
          strobe.captureReq = 1'b1;
          if (lookupHit) strobe.respHit = 1'b1;
          else           stateNext = ST_REQ;
        end
      end
      ST_REQ: begin
        missReqValid = 1'b1;
        if (missReqReady) stateNext = ST_WAIT;
      end
      ST_WAIT: begin
        if (fillValid) begin
          strobe.respFill = 1'b1;
          strobe.install  = fillLive;
          stateNext       = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  // A request not yet taken by the home node stays up.
  assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (missReqValid && !missReqReady) |=> missReqValid);

  // An accepted load that misses produces a request on the next cycle.
  assert_miss_issue_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ldValid && ldReady && !lookupHit) |=> (missReqValid && !ldReady));
endmodule

// File: rtl/lease_l1_datapath.sv
module lease_l1_datapath
  import lease_l1_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int TS_W        = 16,
  parameter int LINE_BYTES  = 32,
  parameter int CACHE_BYTES = 8192,
  parameter int WAYS        = 2,
  localparam int LINE_W     = LINE_BYTES * 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [TS_W-1:0]     globalTime,
  input  logic [ADDR_W-1:0]   ldAddr,
  input  logic [LINE_W-1:0]   fillData,
  input  logic [TS_W-1:0]     fillExpiry,
  input  ctlStrobe_t          strobe,
  output logic                lookupHit,
  output logic                fillLive,
  output logic [ADDR_W-1:0]   missReqAddr,
  output logic                ldRespValid,
  output logic [DATA_W-1:0]   ldRespData
);
  localparam int WORDS  = LINE_BYTES / (DATA_W / 8);
  localparam int SETS   = CACHE_BYTES / (LINE_BYTES * WAYS);
  localparam int BYTE_W = $clog2(DATA_W / 8);
  localparam int WIDX_W = $clog2(WORDS);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int SET_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - SET_W - OFF_W;

  logic [TAG_W-1:0]  tagArr  [SETS][WAYS];
  logic [TS_W-1:0]   expArr  [SETS][WAYS];
  logic [LINE_W-1:0] dataArr [SETS][WAYS];
  logic              validArr[SETS][WAYS];
  logic              lruArr  [SETS];   // way to replace next

  logic [ADDR_W-1:0] reqAddr;

  function automatic logic leaseLive(input logic [TS_W-1:0] lease,
                                     input logic [TS_W-1:0] now);
    logic [TS_W-1:0] diff;
    diff = lease - now;
    return (diff != '0) && !diff[TS_W-1];
  endfunction

  function automatic logic [DATA_W-1:0] pickWord(input logic [LINE_W-1:0] line,
                                                 input logic [WIDX_W-1:0] idx);
    logic [DATA_W-1:0] w;
    w = '0;
    for (int i = 0; i < WORDS; i++)
      if (idx == WIDX_W'(i)) w = line[i*DATA_W +: DATA_W];
    return w;
  endfunction

  // Load-side lookup
  logic [SET_W-1:0]  ldSet;
  logic [TAG_W-1:0]  ldTag;
  logic [WIDX_W-1:0] ldWidx;
  logic [WAYS-1:0]   wayHit;
  logic              hitWay;
  logic [DATA_W-1:0] hitWord;

  assign ldSet  = ldAddr[OFF_W +: SET_W];
  assign ldTag  = ldAddr[ADDR_W-1 -: TAG_W];
  assign ldWidx = ldAddr[BYTE_W +: WIDX_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_lookup
    assign wayHit[w] = validArr[ldSet][w] && (tagArr[ldSet][w] == ldTag) &&
                       leaseLive(expArr[ldSet][w], globalTime);
  end

  assign lookupHit = |wayHit;
  assign hitWay    = wayHit[1];
  assign hitWord   = pickWord(dataArr[ldSet][hitWay], ldWidx);

  // Fill side, addressed by the latched request
  logic [SET_W-1:0]  rqSet;
  logic [TAG_W-1:0]  rqTag;
  logic [WIDX_W-1:0] rqWidx;
  logic [WAYS-1:0]   fillMatch;
  logic              victimWay;
  logic [DATA_W-1:0] fillWord;

  assign rqSet  = reqAddr[OFF_W +: SET_W];
  assign rqTag  = reqAddr[ADDR_W-1 -: TAG_W];
  assign rqWidx = reqAddr[BYTE_W +: WIDX_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_match
    assign fillMatch[w] = validArr[rqSet][w] && (tagArr[rqSet][w] == rqTag);
  end

  always_comb begin
    if (fillMatch[0])      victimWay = 1'b0;
    else if (fillMatch[1]) victimWay = 1'b1;
    else                   victimWay = lruArr[rqSet];
  end

  assign fillLive    = leaseLive(fillExpiry, globalTime);
  assign fillWord    = pickWord(fillData, rqWidx);
  assign missReqAddr = {reqAddr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

  // State with reset: valid bits, replacement bits, response
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        lruArr[s] <= 1'b0;
        for (int w = 0; w < WAYS; w++) validArr[s][w] <= 1'b0;
      end
      ldRespValid <= 1'b0;
      ldRespData  <= '0;
      reqAddr     <= '0;
    end else begin
      ldRespValid <= strobe.respHit | strobe.respFill;
      if (strobe.respHit)       ldRespData <= hitWord;
      else if (strobe.respFill) ldRespData <= fillWord;
      if (strobe.captureReq) reqAddr <= ldAddr;
      if (strobe.respHit) lruArr[ldSet] <= ~hitWay;
      if (strobe.install) begin
        validArr[rqSet][victimWay] <= 1'b1;
        lruArr[rqSet]              <= ~victimWay;
      end
    end
  end

  // Payload arrays without reset
  always_ff @(posedge clk) begin
    if (strobe.install) begin
      tagArr[rqSet][victimWay]  <= rqTag;
      expArr[rqSet][victimWay]  <= fillExpiry;
      dataArr[rqSet][victimWay] <= fillData;
    end
  end

  assert_hit_resp_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.respHit |=> (ldRespValid && ldRespData == $past(hitWord)));

  assert_fill_resp_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.respFill |=> (ldRespValid && ldRespData == $past(fillWord)));

  assert_install_live_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.install |-> fillLive);
endmodule

// File: rtl/lease_l1_cache.sv
module lease_l1_cache
  import lease_l1_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int TS_W        = 16,
  parameter int LINE_BYTES  = 32,
  parameter int CACHE_BYTES = 8192,
  localparam int LINE_W     = LINE_BYTES * 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TS_W-1:0]   globalTime,
  input  logic              ldValid,
  input  logic [ADDR_W-1:0] ldAddr,
  output logic              ldReady,
  output logic              ldRespValid,
  output logic [DATA_W-1:0] ldRespData,
  input  logic              stValid,
  input  logic [ADDR_W-1:0] stAddr,
  input  logic [DATA_W-1:0] stData,
  output logic              stReady,
  output logic              homeStValid,
  output logic [ADDR_W-1:0] homeStAddr,
  output logic [DATA_W-1:0] homeStData,
  input  logic              homeStReady,
  output logic              missReqValid,
  output logic [ADDR_W-1:0] missReqAddr,
  input  logic              missReqReady,
  input  logic              fillValid,
  input  logic [LINE_W-1:0] fillData,
  input  logic [TS_W-1:0]   fillExpiry
);
  ctlStrobe_t strobe;
  logic       lookupHit;
  logic       fillLive;

  // Stores never touch the arrays.
  assign homeStValid = stValid;
  assign homeStAddr  = stAddr;
  assign homeStData  = stData;
  assign stReady     = homeStReady;

  lease_l1_ctrl i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .ldValid      (ldValid),
    .lookupHit    (lookupHit),
    .missReqReady (missReqReady),
    .fillValid    (fillValid),
    .fillLive     (fillLive),
    .ldReady      (ldReady),
    .missReqValid (missReqValid),
    .strobe       (strobe)
  );

  lease_l1_datapath #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .TS_W        (TS_W),
    .LINE_BYTES  (LINE_BYTES),
    .CACHE_BYTES (CACHE_BYTES),
    .WAYS        (2)
  ) i_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .globalTime  (globalTime),
    .ldAddr      (ldAddr),
    .fillData    (fillData),
    .fillExpiry  (fillExpiry),
    .strobe      (strobe),
    .lookupHit   (lookupHit),
    .fillLive    (fillLive),
    .missReqAddr (missReqAddr),
    .ldRespValid (ldRespValid),
    .ldRespData  (ldRespData)
  );
endmodule

// File: tb/test_lease_l1_cache.sv
module test_lease_l1_cache;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [15:0]  globalTime = '0;
  logic         ldValid = 1'b0;
  logic [31:0]  ldAddr = '0;
  logic         ldReady, ldRespValid;
  logic [31:0]  ldRespData;
  logic         stValid = 1'b0;
  logic [31:0]  stAddr = '0, stData = '0;
  logic         stReady, homeStValid;
  logic [31:0]  homeStAddr, homeStData;
  logic         homeStReady = 1'b0;
  logic         missReqValid;
  logic [31:0]  missReqAddr;
  logic         missReqReady = 1'b0;
  logic         fillValid = 1'b0;
  logic [255:0] fillData = '0;
  logic [15:0]  fillExpiry = '0;

  always #10 clk = ~clk;  // 50 MHz

  lease_l1_cache i_lease_l1_cache (.*);

  int errors = 0;
  int checks = 0;

  // Reference state built from the requirements
  int          mTag  [128][2];
  logic        mValid[128][2];
  logic [15:0] mExp  [128][2];
  int          mVer  [128][2];
  logic        mLru  [128];
  int          homeVer[int];

  task automatic check(input logic ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic live(input logic [15:0] lease, input logic [15:0] now);
    logic [15:0] d;
    d = lease - now;
    return (d != 16'd0) && !d[15];
  endfunction

  function automatic logic [31:0] wordOf(input int line, input int idx, input int ver);
    return 32'(line * 32'h9E3779B1) ^ 32'(idx * 32'h01000193) ^ 32'(ver * 32'h7F4A7C15);
  endfunction

  function automatic int verOf(input int line);
    return homeVer.exists(line) ? homeVer[line] : 0;
  endfunction

  // Load with optional forced fill lease; returns 1 if it hit.
  task automatic doLoad(input logic [31:0] addr, input logic force_exp,
                        input logic [15:0] forcedLease, output logic wasHit);
    int set, tag, widx, line, hw;
    logic expHit;
    logic [15:0] lease;
    set  = int'(addr[11:5]);
    tag  = int'(addr[31:12]);
    widx = int'(addr[4:2]);
    line = int'(addr[31:5]);
    hw = 0; expHit = 1'b0;
    for (int w = 0; w < 2; w++)
      if (mValid[set][w] && mTag[set][w] == tag && live(mExp[set][w], globalTime)) begin
        expHit = 1'b1; hw = w;
      end
    check(ldReady, "R4 ldReady before load", 32'(ldReady), 32'd1);
    ldValid = 1'b1; ldAddr = addr;
    @(posedge clk); @(negedge clk);
    ldValid = 1'b0;
    wasHit = ldRespValid;
    if (expHit) begin
      check(ldRespValid && !missReqValid, "R2 hit response", 32'(ldRespValid), 32'd1);
      check(ldRespData == wordOf(line, widx, mVer[set][hw]), "R2 hit data",
            ldRespData, wordOf(line, widx, mVer[set][hw]));
      mLru[set] = ~hw[0];
    end else begin
      check(missReqValid && !ldRespValid, "R3 miss expected", 32'(missReqValid), 32'd1);
      check(missReqAddr == {addr[31:5], 5'd0}, "R4 line-aligned address",
            missReqAddr, {addr[31:5], 5'd0});
      if (missReqValid) begin
        repeat ($urandom % 3) begin
          @(posedge clk); @(negedge clk);
          check(missReqValid && !ldReady && missReqAddr == {addr[31:5], 5'd0},
                "R4 request held", 32'(missReqValid), 32'd1);
        end
        missReqReady = 1'b1;
        @(posedge clk); @(negedge clk);
        missReqReady = 1'b0;
        check(!missReqValid && !ldReady, "R4 single outstanding", 32'(ldReady), 32'd0);
        if (force_exp) lease = forcedLease;
        else if ($urandom % 5 == 0) lease = globalTime - 16'($urandom % 4);
        else lease = globalTime + 16'd1 + 16'($urandom % 30);
        for (int i = 0; i < 8; i++) fillData[i*32 +: 32] = wordOf(line, i, verOf(line));
        fillExpiry = lease;
        fillValid  = 1'b1;
        @(posedge clk); @(negedge clk);
        fillValid = 1'b0;
        check(ldRespValid, live(lease, globalTime) ? "R5 fill response" : "R6 expired fill response",
              32'(ldRespValid), 32'd1);
        check(ldRespData == wordOf(line, widx, verOf(line)),
              live(lease, globalTime) ? "R5 forwarded word" : "R6 forwarded word",
              ldRespData, wordOf(line, widx, verOf(line)));
        if (live(lease, globalTime)) begin
          int vw;
          if (mValid[set][0] && mTag[set][0] == tag)      vw = 0;
          else if (mValid[set][1] && mTag[set][1] == tag) vw = 1;
          else vw = int'(mLru[set]);
          mValid[set][vw] = 1'b1; mTag[set][vw] = tag;
          mExp[set][vw] = lease;  mVer[set][vw] = verOf(line);
          mLru[set] = ~vw[0];
        end
      end
    end
    @(posedge clk); @(negedge clk);
  endtask

  task automatic doStore(input logic [31:0] addr, input logic [31:0] data);
    int line;
    line = int'(addr[31:5]);
    stValid = 1'b1; stAddr = addr; stData = data; homeStReady = 1'($urandom % 2);
    #1;
    check(homeStValid && homeStAddr == addr && homeStData == data, "R7 store forwarded",
          homeStAddr, addr);
    check(stReady == homeStReady, "R7 store ready passthrough", 32'(stReady), 32'(homeStReady));
    check(!missReqValid, "R7 store issues no miss", 32'(missReqValid), 32'd0);
    homeVer[line] = verOf(line) + 1;
    @(posedge clk); @(negedge clk);
    stValid = 1'b0; homeStReady = 1'b0;
  endtask

  function automatic logic [31:0] mkAddr(input int tag, input int set, input int word);
    return {20'(tag), 7'(set), 3'(word), 2'b00};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic h;
    void'($urandom(32'd2024));
    for (int s = 0; s < 128; s++) begin
      mLru[s] = 1'b0;
      for (int w = 0; w < 2; w++) begin
        mValid[s][w] = 1'b0; mTag[s][w] = 0; mExp[s][w] = '0; mVer[s][w] = 0;
      end
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    globalTime = 16'd100;
    // R1: reset state
    check(ldReady && !missReqValid && !ldRespValid, "R1 reset outputs", 32'(ldReady), 32'd1);

    // R1/R5: cold miss then live fill; then R2 hit
    doLoad(mkAddr(1, 3, 2), 1'b1, 16'd110, h);
    check(!h, "R1 first load misses", 32'(h), 32'd0);
    doLoad(mkAddr(1, 3, 5), 1'b0, 16'd0, h);
    check(h, "R2 hit after fill", 32'(h), 32'd1);

    // R7: store leaves the cached copy alone
    doStore(mkAddr(1, 3, 5), 32'hDEADBEEF);
    doLoad(mkAddr(1, 3, 5), 1'b0, 16'd0, h);
    check(h, "R7 stale copy still hits", 32'(h), 32'd1);

    // R10 and R3: time alone reaches the lease; exact boundary misses
    globalTime = 16'd109;
    doLoad(mkAddr(1, 3, 0), 1'b0, 16'd0, h);
    check(h, "R3 one before lease hits", 32'(h), 32'd1);
    globalTime = 16'd110;
    doLoad(mkAddr(1, 3, 0), 1'b1, 16'd110, h);
    check(!h, "R10 time expiry misses", 32'(h), 32'd0);

    // R6: the fill above carried a lease equal to now, so not installed
    doLoad(mkAddr(1, 3, 0), 1'b1, 16'd200, h);
    check(!h, "R6 expired fill not installed", 32'(h), 32'd0);

    // R8: LRU with a third tag in set 9
    doLoad(mkAddr(4, 9, 0), 1'b1, 16'd400, h);
    doLoad(mkAddr(5, 9, 0), 1'b1, 16'd400, h);
    doLoad(mkAddr(4, 9, 1), 1'b0, 16'd0, h);
    doLoad(mkAddr(6, 9, 0), 1'b1, 16'd400, h);
    doLoad(mkAddr(4, 9, 2), 1'b0, 16'd0, h);
    check(h, "R8 recently used line kept", 32'(h), 32'd1);
    doLoad(mkAddr(5, 9, 2), 1'b1, 16'd400, h);
    check(!h, "R8 least recent line evicted", 32'(h), 32'd0);

    // R9: wrap-safe comparison
    globalTime = 16'hFFF0;
    doLoad(mkAddr(7, 20, 1), 1'b1, 16'h0010, h);
    doLoad(mkAddr(7, 20, 3), 1'b0, 16'd0, h);
    check(h, "R9 lease across wrap is live", 32'(h), 32'd1);
    doLoad(mkAddr(8, 21, 1), 1'b1, 16'hFFF0 + 16'h8000, h);
    doLoad(mkAddr(8, 21, 1), 1'b1, 16'h0005, h);
    check(!h, "R9 half-range lease is expired", 32'(h), 32'd0);

    // Constrained random mix
    for (int n = 0; n < 400; n++) begin
      globalTime = globalTime + 16'($urandom % 3);
      if ($urandom % 10 < 2)
        doStore(mkAddr(int'($urandom % 3), 8 + int'($urandom % 4), int'($urandom % 8)), $urandom);
      else
        doLoad(mkAddr(int'($urandom % 3), 8 + int'($urandom % 4), int'($urandom % 8)), 1'b0, 16'd0, h);
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule